// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block produces and verifies even parity for a 64-bit multiplexed address/data bus that carries eight command/byte-enable lines beside it. Each cycle the bus agent tells the block, through per-cycle flags, whether it drives the bus itself and what kind of cycle is on the wires: an address phase, a data phase, a target selection, a special broadcast cycle, and the state of the two active-low width-negotiation lines. The parity over the low half (32 data lines plus 4 enable lines) and over the high half (the upper 32 and upper 4) comes out one clock after the bus value it covers.

When the agent receives a cycle, the block holds its own parity for that cycle and compares it with the parity lines of the following clock. A mismatch in a data phase of a transaction with a selected target gives a one-clock low pulse on the data-error output. A mismatch in an address phase, or in the data of a special broadcast cycle, gives the same kind of pulse on the system-error output. Both pulses appear two clocks after the bus value. Each error output also sets its own sticky flag, and a write-one-to-clear input resets that flag.

The reset input is asynchronous and active low. It is expected to be released in step with the clock by the surrounding logic.

Top module: `bus_parity_unit`

## Requirements
- R1: `par_o` is the XOR of `ad_i[31:0]` and `cbe_i[3:0]`, so the 37 bits together have even parity. It is presented one clock after the bus value it covers. Byte-enable values never remove any data byte from the calculation.
- R2: `par_oe_o` is high in exactly the clock that follows a clock with `drive_i` high, and low otherwise.
- R3: `par64_oe_o` is high in the clock after a driven cycle only when the high half is qualified, and `par64_o` is then the XOR of `ad_i[63:32]` and `cbe_i[7:4]`. In an address phase the high half is qualified when `req64_n_i` is 0. In a data phase it is qualified only when both `req64_n_i` and `ack64_n_i` are 0.
- R4: When the agent receives a data phase (`drive_i`=0, `data_i`=1, `sel_i`=1, `spec_i`=0) and the parity sampled on the next clock mismatches, `perr_n_o` is 0 for one clock, two clocks after the bus value.
- R5: `perr_n_o` stays 1 for mismatches on cycles the agent drove itself, and for data phases with no selected target.
- R6: A parity mismatch on a received address phase drives `serr_n_o` to 0 for one clock, two clocks after the bus value, and leaves `perr_n_o` at 1.
- R7: A parity mismatch in the data of a received special cycle (`spec_i`=1) is reported on `serr_n_o` and never on `perr_n_o`.
- R8: A mismatch on `par64_rx_i` counts as an error only when the high half was qualified under the rule of R3.
- R9: Each error pulse sets its sticky flag (`perr_flag_o`, `serr_flag_o`) on the same edge as the pulse. The flag holds until its clear input is 1 at a clock edge. A new error on the same edge as a clear wins.
- R10: While reset is active, both error outputs are 1 and both output-enable outputs and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_i | input | 64 | Address/data lines as seen this clock |
| cbe_i | input | 8 | Command/byte-enable lines as seen this clock |
| drive_i | input | 1 | Local agent drives the bus this clock |
| addr_i | input | 1 | This clock is an address phase |
| data_i | input | 1 | This clock is a data phase |
| sel_i | input | 1 | A target is selected for the current transaction |
| spec_i | input | 1 | The current transaction is a special broadcast cycle |
| req64_n_i | input | 1 | 64-bit request line, active low |
| ack64_n_i | input | 1 | 64-bit acknowledge line, active low |
| par_rx_i | input | 1 | Received low-half parity line |
| par64_rx_i | input | 1 | Received high-half parity line |
| perr_clr_i | input | 1 | Write-one-to-clear for the data-error flag |
| serr_clr_i | input | 1 | Write-one-to-clear for the system-error flag |
| par_o | output | 1 | Generated low-half parity |
| par64_o | output | 1 | Generated high-half parity |
| par_oe_o | output | 1 | Enable for driving `par_o` |
| par64_oe_o | output | 1 | Enable for driving `par64_o` |
| perr_n_o | output | 1 | Data parity error pulse, active low |
| serr_n_o | output | 1 | System error pulse, active low |
| perr_flag_o | output | 1 | Sticky data-error flag |
| serr_flag_o | output | 1 | Sticky system-error flag |

## Verification
The hardest cases to reach are a high-half mismatch that must be ignored because only one of the two width lines was low, and an error pulse that lands on the same edge as a flag clear. Both depend on a cycle and its parity clock lining up correctly. The stimulus task therefore drives each cycle's received parity from the previous call's bus value, with a chosen bit inverted. It can also raise a clear in the exact call whose edge carries the previous cycle's error. This places the mismatch and the clear on chosen edges.

// File: rtl/bpu_pkg.sv
package bpu_pkg;

  // Flags of one bus clock, kept for the parity clock that follows it.
  typedef struct packed {
    logic drive;
    logic addr;
    logic data;
    logic sel;
    logic spec;
    logic wide;
  } bpu_flags_t;

endpackage

// File: rtl/bpu_lane_parity.sv
module bpu_lane_parity #(
  parameter int LANE_AD_W = 32,
  parameter int LANE_BE_W = 4
) (
  input  logic [LANE_AD_W-1:0] ad_i,
  input  logic [LANE_BE_W-1:0] cbe_i,
  output logic                 par_o
);

  // Even parity: the XOR over every line, whatever the enables say.
  always_comb begin
    par_o = ^{ad_i, cbe_i};
  end

endmodule

// File: rtl/bpu_stage.sv
module bpu_stage
  import bpu_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bpu_flags_t       flags_i,
  input  logic [LANES-1:0] par_i,
  output bpu_flags_t       flags_q,
  output logic [LANES-1:0] par_q,
  output logic             par_oe_o,
  output logic             par64_oe_o
);

  logic             cap_en;
  bpu_flags_t       flags_d;
  logic [LANES-1:0] par_d;

  always_comb begin
    cap_en  = flags_i.drive | flags_i.addr | flags_i.data;
    flags_d = flags_i;
    par_d   = cap_en ? par_i : par_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      par_q   <= '0;
    end else begin
      flags_q <= flags_d;
      par_q   <= par_d;
    end
  end

  always_comb begin
    par_oe_o   = flags_q.drive;
    par64_oe_o = flags_q.drive & flags_q.wide;
  end

  AST_OE_AFTER_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    flags_i.drive |=> par_oe_o); // R2

  AST_OE64_WITHIN_OE: assert property (@(posedge clk) disable iff (!rst_n)
    par64_oe_o |-> par_oe_o); // R3

endmodule

// File: rtl/bpu_check.sv
module bpu_check
  import bpu_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bpu_flags_t       flags_q,
  input  logic [LANES-1:0] par_q,
  input  logic [LANES-1:0] par_rx_i,
  output logic             perr_set_o,
  output logic             serr_set_o,
  output logic             perr_n_o,
  output logic             serr_n_o
);

  logic [LANES-1:0] lane_bad;
  logic             mismatch;
  logic             rx;

  // Lane 0 is always checked; the upper lanes only when qualified.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_low
      assign lane_bad[g] = par_q[g] ^ par_rx_i[g];
    end else begin : g_high
      assign lane_bad[g] = flags_q.wide & (par_q[g] ^ par_rx_i[g]);
    end
  end

  always_comb begin
    mismatch   = |lane_bad;
    rx         = ~flags_q.drive;
    perr_set_o = rx & mismatch & flags_q.data & ~flags_q.addr
                 & flags_q.sel & ~flags_q.spec;
    serr_set_o = rx & mismatch
                 & (flags_q.addr | (flags_q.data & flags_q.spec));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perr_n_o <= 1'b1;
      serr_n_o <= 1'b1;
    end else begin
      perr_n_o <= ~perr_set_o;
      serr_n_o <= ~serr_set_o;
    end
  end

  AST_NO_PERR_ON_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q.drive |=> perr_n_o); // R5

  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!perr_n_o && !serr_n_o)); // R6

endmodule

// File: rtl/bpu_sticky.sv
module bpu_sticky #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_q
);

  logic [N-1:0] flag_d;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_comb begin
      flag_d[g] = set_i[g] | (flag_q[g] & ~clr_i[g]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> (|flag_q)); // R9

endmodule

// File: rtl/bus_parity_unit.sv
module bus_parity_unit
  import bpu_pkg::*;
#(
  parameter int LANE_AD_W = 32,
  parameter int LANE_BE_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2*LANE_AD_W-1:0]   ad_i,
  input  logic [2*LANE_BE_W-1:0]   cbe_i,
  input  logic                     drive_i,
  input  logic                     addr_i,
  input  logic                     data_i,
  input  logic                     sel_i,
  input  logic                     spec_i,
  input  logic                     req64_n_i,
  input  logic                     ack64_n_i,
  input  logic                     par_rx_i,
  input  logic                     par64_rx_i,
  input  logic                     perr_clr_i,
  input  logic                     serr_clr_i,
  output logic                     par_o,
  output logic                     par64_o,
  output logic                     par_oe_o,
  output logic                     par64_oe_o,
  output logic                     perr_n_o,
  output logic                     serr_n_o,
  output logic                     perr_flag_o,
  output logic                     serr_flag_o
);

  localparam int LANES = 2;

  bpu_flags_t       flags_in;
  bpu_flags_t       flags_q;
  logic [LANES-1:0] lane_par;
  logic [LANES-1:0] par_q;
  logic             perr_set;
  logic             serr_set;
  logic [1:0]       flags_out;

  for (genvar g = 0; g < LANES; g++) begin : g_par
    bpu_lane_parity #(.LANE_AD_W(LANE_AD_W), .LANE_BE_W(LANE_BE_W)) u_lane (
      .ad_i  (ad_i[g*LANE_AD_W +: LANE_AD_W]),
      .cbe_i (cbe_i[g*LANE_BE_W +: LANE_BE_W]),
      .par_o (lane_par[g])
    );
  end

  // High-half qualification from the width-negotiation lines.
  always_comb begin
    flags_in.drive = drive_i;
    flags_in.addr  = addr_i;
    flags_in.data  = data_i;
    flags_in.sel   = sel_i;
    flags_in.spec  = spec_i;
    flags_in.wide  = addr_i ? ~req64_n_i
                   : (data_i & ~req64_n_i & ~ack64_n_i);
  end

  bpu_stage #(.LANES(LANES)) u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .flags_i    (flags_in),
    .par_i      (lane_par),
    .flags_q    (flags_q),
    .par_q      (par_q),
    .par_oe_o   (par_oe_o),
    .par64_oe_o (par64_oe_o)
  );

  bpu_check #(.LANES(LANES)) u_check (
    .clk        (clk),
    .rst_n      (rst_n),
    .flags_q    (flags_q),
    .par_q      (par_q),
    .par_rx_i   ({par64_rx_i, par_rx_i}),
    .perr_set_o (perr_set),
    .serr_set_o (serr_set),
    .perr_n_o   (perr_n_o),
    .serr_n_o   (serr_n_o)
  );

  bpu_sticky #(.N(2)) u_sticky (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  ({serr_set, perr_set}),
    .clr_i  ({serr_clr_i, perr_clr_i}),
    .flag_q (flags_out)
  );

  always_comb begin
    par_o       = par_q[0];
    par64_o     = par_q[1];
    perr_flag_o = flags_out[0];
    serr_flag_o = flags_out[1];
  end

  AST_PERR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n_o |-> perr_flag_o); // R9

  AST_SERR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_n_o |-> serr_flag_o); // R9

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_i && !data_i) |=> ##1 (perr_n_o && serr_n_o)); // R4

endmodule

// File: tb/tb_bus_parity_unit.sv
module tb_bus_parity_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] ad_i;
  logic [7:0]  cbe_i;
  logic drive_i, addr_i, data_i, sel_i, spec_i, req64_n_i, ack64_n_i;
  logic par_rx_i, par64_rx_i, perr_clr_i, serr_clr_i;
  logic par_o, par64_o, par_oe_o, par64_oe_o, perr_n_o, serr_n_o;
  logic perr_flag_o, serr_flag_o;

  always #4 clk = ~clk;  // 125 MHz

  bus_parity_unit dut (
    .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .cbe_i(cbe_i),
    .drive_i(drive_i), .addr_i(addr_i), .data_i(data_i), .sel_i(sel_i),
    .spec_i(spec_i), .req64_n_i(req64_n_i), .ack64_n_i(ack64_n_i),
    .par_rx_i(par_rx_i), .par64_rx_i(par64_rx_i),
    .perr_clr_i(perr_clr_i), .serr_clr_i(serr_clr_i),
    .par_o(par_o), .par64_o(par64_o), .par_oe_o(par_oe_o),
    .par64_oe_o(par64_oe_o), .perr_n_o(perr_n_o), .serr_n_o(serr_n_o),
    .perr_flag_o(perr_flag_o), .serr_flag_o(serr_flag_o)
  );

  typedef struct {
    int    at;
    logic  oe, oe64, par, par64;
    logic  perr_n, serr_n, pf, sf;
    string tag_now, tag_err;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_errors = 0;
  int   edge_n   = 0;
  bit   finished = 0;

  // Pending state from the previous stimulus call.
  logic  pend_rx_lo = 0, pend_rx_hi = 0;
  logic  pend_perr = 0, pend_serr = 0;
  string pend_tag = "R4";
  logic  m_pf = 0, m_sf = 0;

  task automatic check1(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%b expected=%b (edge %0d)", tag, act, exp, edge_n);
    end
  endtask

  // Drives one bus clock and queues the expectations that fall on its edge.
  task automatic step(input logic [63:0] ad, input logic [7:0] cbe,
                      input logic drv, input logic ap, input logic dp,
                      input logic sel, input logic spc,
                      input logic r64n, input logic a64n,
                      input logic flo, input logic fhi,
                      input logic pclr, input logic sclr, input string tag);
    exp_t  e;
    logic  plo, phi, wide, rx;
    @(negedge clk);
    ad_i = ad; cbe_i = cbe; drive_i = drv; addr_i = ap; data_i = dp;
    sel_i = sel; spec_i = spc; req64_n_i = r64n; ack64_n_i = a64n;
    par_rx_i = pend_rx_lo; par64_rx_i = pend_rx_hi;
    perr_clr_i = pclr; serr_clr_i = sclr;
    plo  = ^{ad[31:0], cbe[3:0]};
    phi  = ^{ad[63:32], cbe[7:4]};
    wide = ap ? !r64n : (dp && !r64n && !a64n);
    // Expectations on the next edge: this call's parity, previous call's errors.
    m_pf = pend_perr | (m_pf & !pclr);
    m_sf = pend_serr | (m_sf & !sclr);
    e.at = edge_n + 1;
    e.oe = drv; e.oe64 = drv && wide; e.par = plo; e.par64 = phi;
    e.perr_n = !pend_perr; e.serr_n = !pend_serr; e.pf = m_pf; e.sf = m_sf;
    e.tag_now = tag; e.tag_err = pend_tag;
    q.push_back(e);
    // Received parity for next clock, with requested inversions.
    pend_rx_lo = plo ^ flo;
    pend_rx_hi = phi ^ fhi;
    rx = !drv;
    pend_perr = rx && dp && !ap && sel && !spc && (flo || (wide && fhi));
    pend_serr = rx && (ap || (dp && spc)) && (flo || (wide && fhi));
    pend_tag  = tag;
  endtask

  task automatic idle(input logic pclr, input logic sclr);
    step(64'h0, 8'h0, 0, 0, 0, 0, 0, 1, 1, 0, 0, pclr, sclr, "R2");
  endtask

  // Monitor: pops expectations as the design produces results.
  always @(posedge clk) begin
    edge_n++;
    #2;
    while (q.size() > 0 && q[0].at <= edge_n) begin
      exp_t e;
      e = q.pop_front();
      check1({e.tag_now, " R2 par_oe"}, par_oe_o, e.oe);
      check1({e.tag_now, " R3 par64_oe"}, par64_oe_o, e.oe64);
      if (e.oe)   check1({e.tag_now, " R1 par"}, par_o, e.par);
      if (e.oe64) check1({e.tag_now, " R3 par64"}, par64_o, e.par64);
      check1({e.tag_err, " perr_n"}, perr_n_o, e.perr_n);
      check1({e.tag_err, " serr_n"}, serr_n_o, e.serr_n);
      check1({e.tag_err, " R9 perr_flag"}, perr_flag_o, e.pf);
      check1({e.tag_err, " R9 serr_flag"}, serr_flag_o, e.sf);
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    ad_i = '0; cbe_i = '0; drive_i = 0; addr_i = 0; data_i = 0; sel_i = 0;
    spec_i = 0; req64_n_i = 1; ack64_n_i = 1; par_rx_i = 0; par64_rx_i = 0;
    perr_clr_i = 0; serr_clr_i = 0;
    repeat (3) @(posedge clk);
    #2;
    check1("R10 perr_n reset", perr_n_o, 1'b1);
    check1("R10 serr_n reset", serr_n_o, 1'b1);
    check1("R10 par_oe reset", par_oe_o, 1'b0);
    check1("R10 par64_oe reset", par64_oe_o, 1'b0);
    check1("R10 flags reset", perr_flag_o | serr_flag_o, 1'b0);
    @(negedge clk);
    rst_n = 1;

    idle(0, 0);
    // Driven cycles: parity generation and high-half qualification.
    step(64'h1234_5678_9ABC_DEF0, 8'h76, 1, 1, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R3 addr64");
    step(64'hFFFF_0000_0F0F_00FF, 8'h30, 1, 0, 1, 1, 0, 0, 1, 0, 0, 0, 0, "R3 nack");
    step(64'h8000_0001_7FFF_FFFE, 8'h5A, 1, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, "R3 both");
    step(64'h0000_0000_0001_0000, 8'hFF, 1, 0, 1, 1, 0, 1, 1, 0, 0, 0, 0, "R1 masked");
    step(64'h0000_0000_0003_0000, 8'hFF, 1, 0, 1, 1, 0, 1, 1, 1, 1, 0, 0, "R5 driven");
    idle(0, 0);
    // Received cycles.
    step(64'hCAFE_F00D_DEAD_BEEF, 8'h0F, 0, 0, 1, 1, 0, 1, 1, 0, 0, 0, 0, "R4 good");
    step(64'h0000_0000_A5A5_A5A5, 8'h00, 0, 0, 1, 1, 0, 1, 1, 1, 0, 0, 0, "R4 bad");
    idle(0, 0);
    idle(1, 0);
    step(64'h0000_0000_1111_1111, 8'h01, 0, 0, 1, 0, 0, 1, 1, 1, 0, 0, 0, "R5 nosel");
    idle(0, 0);
    step(64'h0000_0000_2222_2222, 8'h07, 0, 1, 0, 0, 0, 1, 1, 1, 0, 0, 0, "R6 addr");
    idle(0, 0);
    step(64'h0000_0000_0000_0012, 8'h01, 0, 0, 1, 0, 1, 1, 1, 1, 0, 0, 0, "R7 special");
    idle(0, 1);
    step(64'h4444_0000_3333_0000, 8'h20, 0, 0, 1, 1, 0, 0, 1, 0, 1, 0, 0, "R8 unqual");
    idle(0, 0);
    step(64'h4444_0000_3333_0000, 8'h20, 0, 0, 1, 1, 0, 0, 0, 0, 1, 0, 0, "R8 qual");
    step(64'h5555_0000_0000_0000, 8'h80, 0, 1, 0, 0, 0, 0, 1, 0, 1, 0, 0, "R8 addr64");
    idle(1, 1);
    // Error on the same edge as a clear: set wins.
    step(64'h0000_0000_0000_0099, 8'h02, 0, 0, 1, 1, 0, 1, 1, 1, 0, 0, 0, "R9 race");
    idle(1, 0);
    idle(0, 0);
    idle(0, 0);
    repeat (3) @(posedge clk);
    #3;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule